// File: doc/BRIEF.md
# Byte-wise 32-bit Linear Diffusion Layer

This block mixes one 32-bit word into another through a fixed linear map made only of XORs and one-bit byte rotations. The word is seen as four bytes, named here a (bits 7:0), b (bits 15:8), c (bits 23:16) and d (bits 31:24). Two stages of byte updates run in a strict order, and each step reads the values left by the step before it. The map is a bijection on 32-bit words. It can serve as the mixing core of an error-detecting state encoder, or as a diffusion step in a keyed datapath. Wider data is covered by instantiating several copies side by side.

A parameter picks the variant. With `REGISTERED = 1`, the result is captured on an input strobe and shown one cycle later with a valid flag. With `REGISTERED = 0`, the block is purely combinational and passes the strobe straight through.

Top module: `mds_diffuse`

## Requirements
- R1: The byte map T(x) rotates byte x left by one place and then XORs x's bit 1 into bit 0 of the result: T(x) = {x[6:0], x[7] ^ x[1]}. The output matches a model built on this T for every single-bit input word.
- R2: The first stage runs in this order: a ^= b, then c ^= d, then d ^= T(a), then b ^= c. The output matches the model for every value of each byte when the other three bytes are zero.
- R3: The second stage runs after the first, in this order: b = T(b), then a ^= b, then c ^= T(d), then d ^= a, then b ^= c. The output matches the model for random words.
- R4: The result is packed as {c, b, a, d} from bit 31 down to bit 0. So bits 7:0 carry the final d and bits 31:24 carry the final c.
- R5: An all-zero input word gives an all-zero output word.
- R6: For any words x and y, out(x ^ y) equals out(x) ^ out(y).
- R7: A nonzero input word never gives a zero output word.
- R8: With REGISTERED = 1, outWord shows the mapped value of inWord, and outValid is high, in the cycle after a clock edge where inValid is high. outValid is low in the cycle after an edge where inValid is low.
- R9: With REGISTERED = 1, outWord keeps its value across edges where inValid is low, whatever inWord does.
- R10: With REGISTERED = 1, an active-low reset (rstN = 0) clears outWord to zero and outValid to low. The reset acts at once, without waiting for a clock edge.
- R11: With REGISTERED = 0, outValid follows inValid in the same cycle, and outWord is the mapped value of the present inWord.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input strobe |
| inWord | input | 32 | Word to be mixed |
| outValid | output | 1 | Result valid |
| outWord | output | 32 | Mixed word |

## Verification
On every cycle, the assertions check four things. The strobe reaches outValid with the right latency. The output is held while no strobe arrives. A zero word gives a zero result. A nonzero word never gives a zero result. The exact byte arithmetic can only be shown by the bench's scenarios: the step order, the T map and the output packing. The bench sweeps single-bit words, full per-byte ranges and random words against its own step-by-step model, and checks linearity on random pairs. Its scenarios also cover the asynchronous reset clearing the block mid-run and the combinational variant.

// File: rtl/mds_pkg.sv
package mds_pkg;

  localparam int BYTE_W = 8;
  localparam int LANES = 4;
  localparam int WORD_W = BYTE_W * LANES;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    byte_t d;
    byte_t c;
    byte_t b;
    byte_t a;
  } lanes_t;

  typedef struct packed {
    logic load;
    logic clear;
  } mdsCtl_t;

  // rotate left by one, then fold the old bit 1 into bit 0
  function automatic byte_t byteSpin(byte_t x);
    byte_t r;
    r = {x[BYTE_W-2:0], x[BYTE_W-1]};
    r[0] = r[0] ^ x[1];
    return r;
  endfunction

  function automatic lanes_t stageOne(lanes_t s);
    lanes_t t;
    t = s;
    t.a = t.a ^ t.b;
    t.c = t.c ^ t.d;
    t.d = t.d ^ byteSpin(t.a);
    t.b = t.b ^ t.c;
    return t;
  endfunction

  function automatic lanes_t stageTwo(lanes_t s);
    lanes_t t;
    t = s;
    t.b = byteSpin(t.b);
    t.a = t.a ^ t.b;
    t.c = t.c ^ byteSpin(t.d);
    t.d = t.d ^ t.a;
    t.b = t.b ^ t.c;
    return t;
  endfunction

  // output order from the top byte down: c, b, a, d
  function automatic logic [WORD_W-1:0] packOut(lanes_t s);
    return {s.c, s.b, s.a, s.d};
  endfunction

endpackage

// File: rtl/mds_ctrl.sv
module mds_ctrl
  import mds_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output mdsCtl_t ctl,
  output logic    outValid
);

  assign ctl.clear = ~rstN;

  generate
    if (REGISTERED) begin : g_reg
      logic validQ;
      assign ctl.load = inValid;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : g_comb
      assign ctl.load = 1'b0;
      assign outValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/mds_datapath.sv
module mds_datapath
  import mds_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdsCtl_t           ctl,
  input  logic [WORD_W-1:0] inWord,
  output logic [WORD_W-1:0] outWord
);

  lanes_t inLanes;
  lanes_t midLanes;
  lanes_t endLanes;
  logic [WORD_W-1:0] mixed;

  always_comb begin
    inLanes  = lanes_t'(inWord);
    midLanes = stageOne(inLanes);
    endLanes = stageTwo(midLanes);
    mixed    = packOut(endLanes);
  end

  generate
    if (REGISTERED) begin : g_reg
      logic [WORD_W-1:0] wordQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        wordQ <= '0;
        else if (ctl.load) wordQ <= mixed;
      end
      assign outWord = wordQ;
    end else begin : g_comb
      logic unusedCtl;
      assign unusedCtl = ctl.load ^ ctl.clear ^ clk ^ rstN;
      assign outWord = mixed;
    end
  endgenerate

endmodule

// File: rtl/mds_diffuse.sv
module mds_diffuse
  import mds_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] inWord,
  output logic        outValid,
  output logic [31:0] outWord
);

  mdsCtl_t ctl;

  mds_ctrl #(.REGISTERED(REGISTERED)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  mds_datapath #(.REGISTERED(REGISTERED)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .inWord  (inWord),
    .outWord (outWord)
  );

endmodule

// File: rtl/mds_diffuse_checker.sv
module mds_diffuse_checker #(
  parameter bit REGISTERED = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] inWord,
  input logic        outValid,
  input logic [31:0] outWord
);

  generate
    if (REGISTERED) begin : g_reg
      assert_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> (outValid == $past(inValid)));

      assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && !$past(inValid)) |-> $stable(outWord));

      assert_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(inValid) && ($past(inWord) == 32'h0)) |-> (outWord == 32'h0));

      assert_nonzero_R7: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(inValid) && ($past(inWord) != 32'h0)) |-> (outWord != 32'h0));
    end else begin : g_comb
      always @(posedge clk) begin
        if (rstN) begin
          assert_pass_R11: assert (outValid == inValid);
          assert_zero_R5: assert ((inWord != 32'h0) || (outWord == 32'h0));
          assert_nonzero_R7: assert ((inWord == 32'h0) || (outWord != 32'h0));
        end
      end
    end
  endgenerate

endmodule

bind mds_diffuse mds_diffuse_checker #(.REGISTERED(REGISTERED)) u_chk (.*);

// File: tb/tb_mds_diffuse.sv
module tb_mds_diffuse;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic inValid = 1'b0;
  logic [31:0] inWord = 32'h0;
  logic outValid, outValidC;
  logic [31:0] outWord, outWordC;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mds_diffuse #(.REGISTERED(1'b1)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .outWord(outWord));

  mds_diffuse #(.REGISTERED(1'b0)) dutComb (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .outValid(outValidC), .outWord(outWordC));

  function automatic int spin(int x);
    int r;
    r = ((x << 1) | (x >> 7)) & 255;
    return r ^ ((x >> 1) & 1);
  endfunction

  function automatic logic [31:0] model(logic [31:0] w);
    int a, b, c, d;
    a = int'(w[7:0]); b = int'(w[15:8]); c = int'(w[23:16]); d = int'(w[31:24]);
    a = a ^ b; c = c ^ d; d = d ^ spin(a); b = b ^ c;
    b = spin(b); a = a ^ b; c = c ^ spin(d); d = d ^ a; b = b ^ c;
    return {c[7:0], b[7:0], a[7:0], d[7:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic combApply(logic [31:0] w, output logic [31:0] r);
    @(negedge clk);
    inWord = w;
    #1;
    r = outWordC;
  endtask

  task automatic pushReg(logic [31:0] w);
    @(negedge clk);
    inValid = 1'b1;
    inWord = w;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, rx, ry, held;
    #1 rstN = 1'b0;
    #2;
    check("R10 reset word", outWord, 32'h0);
    check("R10 reset valid", {31'h0, outValid}, 32'h0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // R1: every single-bit word
    for (int i = 0; i < 32; i++) begin
      combApply(32'h1 << i, r);
      check("R1 single bit", r, model(32'h1 << i));
    end

    // R2: each byte alone through all its values, register must hold (R9)
    held = outWord;
    for (int lane = 0; lane < 4; lane++) begin
      for (int v = 0; v < 256; v++) begin
        combApply(32'(v) << (8 * lane), r);
        check("R2 byte sweep", r, model(32'(v) << (8 * lane)));
      end
    end
    check("R9 hold during sweep", outWord, held);

    // R5
    combApply(32'h0, r);
    check("R5 zero", r, 32'h0);

    // R4: byte positions; a=1 only gives d final in low byte
    combApply(32'h0000_0001, r);
    check("R4 low byte is d", {24'h0, r[7:0]}, {24'h0, model(32'h1)[7:0]});
    check("R4 top byte is c", {24'h0, r[31:24]}, {24'h0, model(32'h1)[31:24]});

    // R3 random, R7 nonzero
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] w;
      w = $urandom;
      combApply(w, r);
      check("R3 random", r, model(w));
      if (w != 0) begin
        tests++;
        if (r == 0) begin
          fails++;
          $display("FAIL R7: actual %h expected nonzero", r);
        end
      end
    end

    // R6 linearity
    for (int i = 0; i < 300; i++) begin
      logic [31:0] x, y;
      x = $urandom; y = $urandom;
      combApply(x, rx);
      combApply(y, ry);
      combApply(x ^ y, r);
      check("R6 linearity", r, rx ^ ry);
    end

    // R11 comb valid pass-through
    @(negedge clk);
    inValid = 1'b1; inWord = 32'hDEAD_BEEF;
    #1;
    check("R11 comb valid", {31'h0, outValidC}, 32'h1);
    check("R11 comb word", outWordC, model(32'hDEAD_BEEF));
    inValid = 1'b0;
    #1;
    check("R11 comb valid low", {31'h0, outValidC}, 32'h0);

    // R8 registered latency, R9 hold
    for (int i = 0; i < 100; i++) begin
      logic [31:0] w;
      w = $urandom;
      pushReg(w);
      check("R8 reg word", outWord, model(w));
      check("R8 reg valid", {31'h0, outValid}, 32'h1);
      inWord = ~w;
      @(negedge clk);
      check("R8 valid drops", {31'h0, outValid}, 32'h0);
      check("R9 hold", outWord, model(w));
    end

    // back-to-back strobes
    @(negedge clk);
    inValid = 1'b1; inWord = 32'h1234_5678;
    @(negedge clk);
    check("R8 back-to-back first", outWord, model(32'h1234_5678));
    inWord = 32'h8000_0001;
    @(negedge clk);
    check("R8 back-to-back second", outWord, model(32'h8000_0001));
    inValid = 1'b0;

    // R10 mid-run asynchronous reset
    pushReg(32'hCAFE_F00D);
    #2 rstN = 1'b0;
    #1;
    check("R10 async word", outWord, 32'h0);
    check("R10 async valid", {31'h0, outValid}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    pushReg(32'h0);
    check("R5 reg zero", outWord, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule